// File: doc/BRIEF.md
# Address Translation Cache with Selective Flush

This block is the translation cache that sits beside a page table walker in a paged memory management unit. It holds a small number of recent logical-to-physical page translations in a fully associative array. Each entry is keyed by a 3-bit function code and a logical page number. A lookup returns hit or miss, the physical address and a 16-bit status word one clock later. The page size is not fixed: it comes from a shift field in a translation-control word, so the same array serves any page size from 256 bytes to 32 KiB.

The table walker installs translations through the fill port. It passes along the status bits the walk produced, and the cache folds those bits into per-entry flags: bus error, write-protect and modified. A page that has never been written is cached with its modified flag clear. The first write lookup to such a page is turned into a miss, and the entry is dropped at the same time. The walker then runs again and can mark the page descriptor as modified.

Software maintenance comes through the flush inputs. One input clears the whole array. Another clears only the entries whose function code matches a masked value, and it can be narrowed further to a single page.

Top module: `atc_cache`

## Requirements
- R1: After reset every entry is invalid, the round-robin pointer is 0, and res_valid, res_hit, res_paddr and res_status are all 0.
- R2: The page shift ps is ctl_word[23:20], and any value below 8 is taken as 8. A page number is the 24-bit value (address >> ps) << (ps-8), so the logical bits above ps sit at bit positions ps-8 and up.
- R3: A lookup hits when a valid entry has the same function code and the same logical page number under the current ps. The result appears on the clock edge after lk_valid, with res_valid high for exactly that one cycle. A hit gives res_paddr = (stored physical page << 8) OR (low ps bits of the logical address). res_hit, res_paddr and res_status hold their values until the next lookup.
- R4: The status of a hit is the OR of 0x0200 if the entry is modified, 0x0800 if it is write-protected, and 0x8400 if it carries bus error. A miss gives status 0x0400 and res_paddr 0.
- R5: A write lookup (lk_write=1) that matches an entry whose modified flag is clear reports a miss with status 0x0400 and invalidates that entry. A following read lookup of the same page misses.
- R6: A fill sets bus error when fill_status has any of 0x8000, 0x0400 or 0x2000. It sets write-protect when fill_status has 0x0800. It sets modified when fill_write=1 and the page is not write-protected.
- R7: A fill whose function code and page equal those of a valid entry rewrites only that entry's physical page and flags. No other entry changes.
- R8: Any other fill goes to the lowest-numbered invalid entry.
- R9: When every entry is valid, a fill replaces the entry at the round-robin pointer and the pointer then advances, wrapping from ENTRIES-1 to 0.
- R10: flush_all invalidates every entry and returns the round-robin pointer to 0.
- R11: flush_sel invalidates each valid entry whose (function code AND flush_mask) equals (flush_fc AND flush_mask). With flush_by_page=1, the entry's page must also equal the page of flush_laddr under the current ps.
- R12: When a flush and a fill arrive in the same cycle, the flush takes effect and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 32 | Translation-control word; bits 23:20 give the page shift |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | 32 | Lookup logical address |
| lk_fc | input | 3 | Lookup function code |
| lk_write | input | 1 | Lookup is a write access |
| fill_valid | input | 1 | Fill request from the table walker |
| fill_laddr | input | 32 | Logical address of the filled translation |
| fill_paddr | input | 32 | Physical address of the filled translation |
| fill_fc | input | 3 | Function code of the filled translation |
| fill_write | input | 1 | The walk was made for a write |
| fill_status | input | 16 | Status word produced by the walk |
| flush_all | input | 1 | Invalidate all entries |
| flush_sel | input | 1 | Selective flush by function code |
| flush_by_page | input | 1 | Selective flush also compares the page |
| flush_fc | input | 3 | Function code for the selective flush |
| flush_mask | input | 3 | Mask applied to function codes in the selective flush |
| flush_laddr | input | 32 | Logical address for a page-qualified flush |
| res_valid | output | 1 | A lookup result is presented this cycle |
| res_hit | output | 1 | The last lookup hit |
| res_paddr | output | 32 | Physical address of the last lookup (0 on a miss) |
| res_status | output | 16 | Status word of the last lookup |

## Verification
The properties assume that lookup and fill requests are never issued in the same cycle. They also assume ctl_word does not change while a lookup is waiting for its result. Under those conditions the properties can tie the change in valid-entry count directly to a fill, a flush or a forced miss. The stimulus keeps to these assumptions by issuing one request per task call, separated by clock edges. It changes the page shift only between operations, and it combines a flush with a fill on purpose, since that pairing is the defined priority case. The bench's behavioural model follows the same rules. It is stepped on every edge, so any difference in which entry a fill replaces shows up at the next lookup of an affected page.

// File: rtl/atc_pkg.sv
`timescale 1ns/1ps
package atc_pkg;

  localparam int PAGE_W = 24;

  localparam logic [15:0] ST_BUSERR = 16'h8000;
  localparam logic [15:0] ST_SUPER  = 16'h2000;
  localparam logic [15:0] ST_WPROT  = 16'h0800;
  localparam logic [15:0] ST_INVAL  = 16'h0400;
  localparam logic [15:0] ST_MOD    = 16'h0200;

  typedef struct packed {
    logic              valid;
    logic [2:0]        fc;
    logic [PAGE_W-1:0] page;
  } atc_tag_t;

  typedef struct packed {
    logic              be;
    logic              wp;
    logic              mod;
    logic [PAGE_W-1:0] ppage;
  } atc_data_t;

  // effective page shift: field 23:20, floor of 8
  function automatic logic [3:0] eff_shift(input logic [31:0] ctl);
    logic [3:0] s;
    s = ctl[23:20];
    return (s < 4'd8) ? 4'd8 : s;
  endfunction

  // page number: address bits 31:8 with the in-page part cleared
  function automatic logic [PAGE_W-1:0] page_of(input logic [31:0] a, input logic [3:0] ps);
    logic [31:0] keep;
    keep = 32'hFFFF_FFFF << (ps - 4'd8);
    return a[31:8] & keep[PAGE_W-1:0];
  endfunction

  function automatic logic [31:0] offset_mask(input logic [3:0] ps);
    return (32'h1 << ps) - 32'h1;
  endfunction

  function automatic logic [31:0] phys_of(input atc_data_t d, input logic [31:0] la,
                                          input logic [3:0] ps);
    return {d.ppage, 8'h00} | (la & offset_mask(ps));
  endfunction

  function automatic logic [15:0] hit_status(input atc_data_t d);
    logic [15:0] st;
    st = 16'h0000;
    if (d.mod) st = st | ST_MOD;
    if (d.wp)  st = st | ST_WPROT;
    if (d.be)  st = st | ST_BUSERR | ST_INVAL;
    return st;
  endfunction

  function automatic atc_data_t make_data(input logic [31:0] pa, input logic [15:0] walk_st,
                                          input logic wr, input logic [3:0] ps);
    atc_data_t d;
    d.be    = |(walk_st & (ST_BUSERR | ST_INVAL | ST_SUPER));
    d.wp    = |(walk_st & ST_WPROT);
    d.mod   = wr & ~d.wp;
    d.ppage = page_of(pa, ps);
    return d;
  endfunction

endpackage

// File: rtl/atc_match.sv
`timescale 1ns/1ps
module atc_match
  import atc_pkg::*;
#(
  parameter  int ENTRIES = 22,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  atc_tag_t           tags [ENTRIES],
  input  atc_tag_t           probe,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = tags[g].valid && (tags[g] == probe);
  end

  assign any = |hit_vec;

  // lowest matching index wins
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/atc_victim.sv
`timescale 1ns/1ps
module atc_victim #(
  parameter  int ENTRIES = 22,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [IDX_W-1:0]   rr_q,
  output logic [IDX_W-1:0]   slot,
  output logic               full
);

  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &valid_vec;
  assign slot = full ? rr_q : free_idx;

endmodule

// File: rtl/atc_flush_filter.sv
`timescale 1ns/1ps
module atc_flush_filter
  import atc_pkg::*;
#(
  parameter int ENTRIES = 22
) (
  input  atc_tag_t           tags [ENTRIES],
  input  logic               by_page,
  input  logic [2:0]         fc,
  input  logic [2:0]         mask,
  input  logic [PAGE_W-1:0]  page,
  output logic [ENTRIES-1:0] kill
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flt
    logic fc_ok;
    logic pg_ok;
    assign fc_ok   = (tags[g].fc & mask) == (fc & mask);
    assign pg_ok   = !by_page || (tags[g].page == page);
    assign kill[g] = tags[g].valid && fc_ok && pg_ok;
  end

endmodule

// File: rtl/atc_cache.sv
`timescale 1ns/1ps
module atc_cache
  import atc_pkg::*;
#(
  parameter  int ENTRIES = 22,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctl_word,
  input  logic        lk_valid,
  input  logic [31:0] lk_laddr,
  input  logic [2:0]  lk_fc,
  input  logic        lk_write,
  input  logic        fill_valid,
  input  logic [31:0] fill_laddr,
  input  logic [31:0] fill_paddr,
  input  logic [2:0]  fill_fc,
  input  logic        fill_write,
  input  logic [15:0] fill_status,
  input  logic        flush_all,
  input  logic        flush_sel,
  input  logic        flush_by_page,
  input  logic [2:0]  flush_fc,
  input  logic [2:0]  flush_mask,
  input  logic [31:0] flush_laddr,
  output logic        res_valid,
  output logic        res_hit,
  output logic [31:0] res_paddr,
  output logic [15:0] res_status
);

  atc_tag_t  tag_q  [ENTRIES];
  atc_data_t data_q [ENTRIES];

  logic [3:0]         ps;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   rr_q;

  assign ps = eff_shift(ctl_word);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = tag_q[g].valid;
  end

  // ---------------- lookup match ----------------
  atc_tag_t           lk_probe;
  logic [ENTRIES-1:0] lk_vec;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  always_comb begin
    lk_probe.valid = 1'b1;
    lk_probe.fc    = lk_fc;
    lk_probe.page  = page_of(lk_laddr, ps);
  end

  atc_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .tags    (tag_q),
    .probe   (lk_probe),
    .hit_vec (lk_vec),
    .any     (lk_any),
    .idx     (lk_idx)
  );

  atc_data_t lk_data;
  logic      lk_kill;
  logic      lk_hit;

  assign lk_data = data_q[lk_idx];
  assign lk_kill = lk_valid && lk_write && lk_any && !lk_data.mod;
  assign lk_hit  = lk_any && !lk_kill;

  // ---------------- fill placement ----------------
  atc_tag_t           fill_tag;
  atc_data_t          fill_data;
  logic [ENTRIES-1:0] fill_vec;
  logic               fill_dup;
  logic [IDX_W-1:0]   fill_dup_idx;
  logic [IDX_W-1:0]   victim_slot;
  logic               victim_full;

  always_comb begin
    fill_tag.valid = 1'b1;
    fill_tag.fc    = fill_fc;
    fill_tag.page  = page_of(fill_laddr, ps);
  end

  assign fill_data = make_data(fill_paddr, fill_status, fill_write, ps);

  atc_match #(.ENTRIES(ENTRIES)) u_fill_match (
    .tags    (tag_q),
    .probe   (fill_tag),
    .hit_vec (fill_vec),
    .any     (fill_dup),
    .idx     (fill_dup_idx)
  );

  atc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_vec (valid_vec),
    .rr_q      (rr_q),
    .slot      (victim_slot),
    .full      (victim_full)
  );

  // ---------------- flush ----------------
  logic [ENTRIES-1:0] sel_kill;
  logic [ENTRIES-1:0] kill_vec;
  logic               flush_any;
  logic               fill_go;
  logic               rr_step;
  logic [IDX_W-1:0]   fill_slot;

  atc_flush_filter #(.ENTRIES(ENTRIES)) u_flush (
    .tags    (tag_q),
    .by_page (flush_by_page),
    .fc      (flush_fc),
    .mask    (flush_mask),
    .page    (page_of(flush_laddr, ps)),
    .kill    (sel_kill)
  );

  assign flush_any = flush_all || flush_sel;
  assign kill_vec  = flush_all ? {ENTRIES{1'b1}} : (flush_sel ? sel_kill : '0);
  assign fill_go   = fill_valid && !flush_any;
  assign fill_slot = fill_dup ? fill_dup_idx : victim_slot;
  assign rr_step   = fill_go && !fill_dup && victim_full;

  // ---------------- storage ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_go && (fill_slot == IDX_W'(i))) begin
          tag_q[i]  <= fill_tag;
          data_q[i] <= fill_data;
        end else if (kill_vec[i] || (lk_kill && (lk_idx == IDX_W'(i)))) begin
          tag_q[i].valid <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (flush_all) begin
      rr_q <= '0;
    end else if (rr_step) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // ---------------- registered result ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_paddr  <= '0;
      res_status <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit    <= lk_hit;
        res_paddr  <= lk_hit ? phys_of(lk_data, lk_laddr, ps) : 32'h0;
        res_status <= lk_hit ? hit_status(lk_data) : ST_INVAL;
      end
    end
  end

endmodule

// File: rtl/atc_checker.sv
`timescale 1ns/1ps
module atc_checker #(
  parameter  int ENTRIES = 22,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               fill_valid,
  input logic               flush_all,
  input logic               flush_any,
  input logic               lk_kill,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [IDX_W-1:0]   rr_q,
  input logic               res_valid,
  input logic               res_hit,
  input logic [31:0]        res_paddr,
  input logic [15:0]        res_status
);

  // R3: one result per lookup, on the next edge
  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R4: miss shape and invalid flag tied to bus error on hits
  a_r4_miss_status: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_status == 16'h0400 && res_paddr == 32'h0));
  a_r4_hit_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_status[10] == res_status[15]));

  // R5: forced miss drops the entry
  a_r5_forced_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_kill |=> !res_hit);
  a_r5_entry_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kill && !fill_valid) |=> ($countones(valid_vec) < $past($countones(valid_vec))));

  // R8: a fill that survives leaves at least as many valid entries
  a_r8_fill_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_any && !lk_kill) |=>
      (($countones(valid_vec) >= $past($countones(valid_vec))) && (|valid_vec)));

  // R9: pointer range
  a_r9_rr_range: assert property (@(posedge clk) disable iff (!rst_n)
    rr_q < IDX_W'(ENTRIES));

  // R10: flush-all empties the array and rewinds the pointer
  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> ((valid_vec == '0) && (rr_q == '0)));

  // R12: a flush never lets a same-cycle fill add an entry
  a_r12_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_any && fill_valid) |=> ($countones(valid_vec) <= $past($countones(valid_vec))));

endmodule

bind atc_cache atc_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .fill_valid (fill_valid),
  .flush_all  (flush_all),
  .flush_any  (flush_any),
  .lk_kill    (lk_kill),
  .valid_vec  (valid_vec),
  .rr_q       (rr_q),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_paddr  (res_paddr),
  .res_status (res_status)
);

// File: tb/tb_atc_cache.sv
`timescale 1ns/1ps
module tb_atc_cache;

  localparam int N = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl_word = 32'h00C0_0000;
  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_laddr = 0;
  logic [2:0]  lk_fc = 0;
  logic        fill_valid = 0, fill_write = 0;
  logic [31:0] fill_laddr = 0, fill_paddr = 0;
  logic [2:0]  fill_fc = 0;
  logic [15:0] fill_status = 0;
  logic        flush_all = 0, flush_sel = 0, flush_by_page = 0;
  logic [2:0]  flush_fc = 0, flush_mask = 0;
  logic [31:0] flush_laddr = 0;
  logic        res_valid, res_hit;
  logic [31:0] res_paddr;
  logic [15:0] res_status;

  always #2.5 clk = ~clk;

  atc_cache #(.ENTRIES(N)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // ---------------- behavioural reference ----------------
  bit          m_v   [N];
  bit [2:0]    m_fc  [N];
  bit [23:0]   m_pg  [N];
  bit [23:0]   m_pp  [N];
  bit          m_be  [N], m_wp [N], m_md [N];
  int          m_rr;
  bit          e_valid, e_hit;
  bit [31:0]   e_paddr;
  bit [15:0]   e_status;

  function automatic int shift_now();
    int s = int'(ctl_word[23:20]);
    return (s < 8) ? 8 : s;
  endfunction

  function automatic bit [23:0] pg(bit [31:0] a, int s);
    bit [31:0] t;
    t = (a >> s) << (s - 8);
    return t[23:0];
  endfunction

  function automatic int find(bit [2:0] fc, bit [23:0] p);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_fc[i] == fc && m_pg[i] == p) return i;
    return -1;
  endfunction

  task automatic model_step();
    int s = shift_now();
    int li = find(lk_fc, pg(lk_laddr, s));
    int fi = find(fill_fc, pg(fill_laddr, s));
    int fr = -1;
    int slot;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) fr = i;
    e_valid = lk_valid;
    if (lk_valid) begin
      if (li >= 0 && !(lk_write && !m_md[li])) begin
        e_hit = 1;
        e_paddr = ({8'h00, m_pp[li]} << 8) | (lk_laddr % (64'd1 << s));
        e_status = (m_md[li] ? 16'h0200 : 16'h0) | (m_wp[li] ? 16'h0800 : 16'h0)
                 | (m_be[li] ? 16'h8400 : 16'h0);
      end else begin
        e_hit = 0; e_paddr = 0; e_status = 16'h0400;
      end
    end
    if (flush_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0;
    end else if (flush_sel) begin
      for (int i = 0; i < N; i++)
        if (m_v[i] && ((m_fc[i] & flush_mask) == (flush_fc & flush_mask)) &&
            (!flush_by_page || m_pg[i] == pg(flush_laddr, s))) m_v[i] = 0;
    end
    if (lk_valid && li >= 0 && lk_write && !m_md[li]) m_v[li] = 0;
    if (fill_valid && !flush_all && !flush_sel) begin
      if (fi >= 0) slot = fi;
      else if (fr >= 0) slot = fr;
      else begin slot = m_rr; m_rr = (m_rr + 1) % N; end
      m_v[slot] = 1; m_fc[slot] = fill_fc; m_pg[slot] = pg(fill_laddr, s);
      m_pp[slot] = pg(fill_paddr, s);
      m_be[slot] = (fill_status & 16'hA400) != 0;
      m_wp[slot] = fill_status[11];
      m_md[slot] = fill_write && !fill_status[11];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0; e_valid = 0; e_hit = 0; e_paddr = 0; e_status = 0;
    end else model_step();
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R3, R4)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model res_valid", 32'(res_valid), 32'(e_valid));
      if (e_valid) begin
        chk("R3 model res_hit", 32'(res_hit), 32'(e_hit));
        chk("R3 model res_paddr", res_paddr, e_paddr);
        chk("R4 model res_status", 32'(res_status), 32'(e_status));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic t_fill(bit [31:0] la, bit [31:0] pa, bit [2:0] fc, bit wr, bit [15:0] st);
    fill_valid = 1; fill_laddr = la; fill_paddr = pa; fill_fc = fc;
    fill_write = wr; fill_status = st;
    @(posedge clk); #1 fill_valid = 0;
  endtask

  task automatic t_look(bit [31:0] la, bit [2:0] fc, bit wr);
    lk_valid = 1; lk_laddr = la; lk_fc = fc; lk_write = wr;
    @(posedge clk); #1 lk_valid = 0;
  endtask

  task automatic look_hit(bit [31:0] la, bit [2:0] fc, bit wr, bit exp, string req);
    t_look(la, fc, wr);
    chk(req, 32'(res_hit), 32'(exp));
  endtask

  task automatic t_flush_all();
    flush_all = 1; @(posedge clk); #1 flush_all = 0;
  endtask

  task automatic t_flush_sel(bit [2:0] fc, bit [2:0] mask, bit bypg, bit [31:0] la);
    flush_sel = 1; flush_fc = fc; flush_mask = mask; flush_by_page = bypg; flush_laddr = la;
    @(posedge clk); #1 flush_sel = 0; flush_by_page = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset res_valid", 32'(res_valid), 0);
    chk("R1 reset res_hit", 32'(res_hit), 0);
    chk("R1 reset res_status", 32'(res_status), 0);
    chk("R1 reset res_paddr", res_paddr, 0);
    rst_n = 1;
    @(posedge clk); #1;
    look_hit(32'h1234_5678, 3'd5, 0, 0, "R1 empty after reset");
    chk("R4 miss status", 32'(res_status), 32'h0400);

    // R3: basic hit, ps = 12
    t_fill(32'h1234_5000, 32'hABCD_E000, 3'd5, 0, 16'h0);
    look_hit(32'h1234_5678, 3'd5, 0, 1, "R3 hit");
    chk("R3 hit paddr", res_paddr, 32'hABCD_E678);
    chk("R4 clean status", 32'(res_status), 32'h0);
    look_hit(32'h1234_5678, 3'd1, 0, 0, "R3 fc mismatch misses");

    // R5: write to unmodified page
    look_hit(32'h1234_5678, 3'd5, 1, 0, "R5 forced miss");
    look_hit(32'h1234_5678, 3'd5, 0, 0, "R5 entry dropped");

    // R6: modified via write fill
    t_fill(32'h1234_5000, 32'hABCD_E000, 3'd5, 1, 16'h0);
    look_hit(32'h1234_5010, 3'd5, 1, 1, "R6 modified write hit");
    chk("R6 modified status", 32'(res_status), 32'h0200);

    t_fill(32'h2000_0000, 32'h3000_0000, 3'd1, 1, 16'h0800);
    look_hit(32'h2000_0004, 3'd1, 0, 1, "R6 wp read hit");
    chk("R6 wp status", 32'(res_status), 32'h0800);
    look_hit(32'h2000_0004, 3'd1, 1, 0, "R5 write to wp page misses");

    t_fill(32'h4000_0000, 32'h5000_0000, 3'd1, 0, 16'h2000);
    look_hit(32'h4000_0000, 3'd1, 0, 1, "R6 super-only hit");
    chk("R6 super-only gives bus error", 32'(res_status), 32'h8400);
    t_fill(32'h4400_0000, 32'h5400_0000, 3'd1, 0, 16'h0400);
    look_hit(32'h4400_0000, 3'd1, 0, 1, "R6 invalid hit");
    chk("R6 invalid gives bus error", 32'(res_status), 32'h8400);

    // R2: page shift change
    ctl_word = 32'h0000_0000;
    look_hit(32'h1234_5678, 3'd5, 0, 0, "R2 ps8 different page");
    look_hit(32'h1234_5078, 3'd5, 0, 1, "R2 ps8 same page");
    chk("R2 ps8 paddr", res_paddr, 32'hABCD_E078);
    ctl_word = 32'h0030_0000;
    look_hit(32'h1234_5078, 3'd5, 0, 1, "R2 shift below 8 clamps");
    ctl_word = 32'h00F0_0000;
    t_fill(32'h8000_0000, 32'h1000_0000, 3'd2, 0, 16'h0);
    look_hit(32'h8000_7ABC, 3'd2, 0, 1, "R2 ps15 hit");
    chk("R2 ps15 paddr", res_paddr, 32'h1000_7ABC);

    // R10
    t_flush_all();
    look_hit(32'h8000_7ABC, 3'd2, 0, 0, "R10 flushed");
    ctl_word = 32'h00C0_0000;
    look_hit(32'h1234_5010, 3'd5, 0, 0, "R10 flushed second");

    // R8 / R9 fill order
    for (int i = 0; i < N; i++) t_fill(32'(i) << 12, (32'h100 + 32'(i)) << 12, 3'd5, 0, 16'h0);
    t_fill(32'(22) << 12, 32'h0009_9000, 3'd5, 0, 16'h0);
    look_hit(32'h0000_0000, 3'd5, 0, 0, "R9 slot 0 replaced");
    look_hit(32'h0000_1000, 3'd5, 0, 1, "R9 slot 1 kept");
    look_hit(32'h0001_6000, 3'd5, 0, 1, "R9 new entry hit");
    t_fill(32'(23) << 12, 32'h0009_A000, 3'd5, 0, 16'h0);
    look_hit(32'h0000_1000, 3'd5, 0, 0, "R9 pointer advanced");
    look_hit(32'h0000_2000, 3'd5, 0, 1, "R9 slot 2 kept");

    // R7 duplicate fill
    t_fill(32'h0000_5000, 32'h0077_7000, 3'd5, 0, 16'h0);
    look_hit(32'h0000_5123, 3'd5, 0, 1, "R7 rewritten hit");
    chk("R7 new physical page", res_paddr, 32'h0077_7123);
    look_hit(32'h0000_2000, 3'd5, 0, 1, "R7 no eviction");

    // R11 page-qualified flush, then R8 free slot reuse
    t_flush_sel(3'd5, 3'd7, 1, 32'h0000_A000);
    look_hit(32'h0000_A000, 3'd5, 0, 0, "R11 page flush");
    look_hit(32'h0000_B000, 3'd5, 0, 1, "R11 other page kept");
    t_fill(32'h0001_E000, 32'h0004_4000, 3'd5, 0, 16'h0);
    look_hit(32'h0000_2000, 3'd5, 0, 1, "R8 free slot used first");
    look_hit(32'h0001_E000, 3'd5, 0, 1, "R8 new entry hit");

    // R11 masked function-code flush
    t_flush_sel(3'd2, 3'd7, 0, 32'h0);
    look_hit(32'h0000_2000, 3'd5, 0, 1, "R11 non-matching fc kept");
    t_flush_sel(3'd1, 3'd3, 0, 32'h0);
    look_hit(32'h0000_2000, 3'd5, 0, 0, "R11 masked fc flush");

    // R10 pointer rewind
    t_flush_all();
    for (int i = 0; i < N; i++) t_fill(32'(i) << 12, 32'(i) << 12, 3'd5, 0, 16'h0);
    t_fill(32'h0003_0000, 32'h0003_0000, 3'd5, 0, 16'h0);
    look_hit(32'h0000_0000, 3'd5, 0, 0, "R10 pointer back at 0");
    look_hit(32'h0000_2000, 3'd5, 0, 1, "R10 slot 2 kept");

    // R12 flush beats fill
    t_flush_all();
    flush_all = 1; fill_valid = 1; fill_laddr = 32'h0006_0000; fill_paddr = 32'h0006_0000;
    fill_fc = 3'd3; fill_write = 0; fill_status = 0;
    @(posedge clk); #1 flush_all = 0; fill_valid = 0;
    look_hit(32'h0006_0000, 3'd3, 0, 0, "R12 fill dropped by flush-all");
    flush_sel = 1; flush_fc = 3'd0; flush_mask = 3'd7; fill_valid = 1;
    @(posedge clk); #1 flush_sel = 0; fill_valid = 0;
    look_hit(32'h0006_0000, 3'd3, 0, 0, "R12 fill dropped by selective flush");

    repeat (2) @(posedge clk);
    #1 finish_up();
  end

endmodule